// File: doc/BRIEF.md
# Two-Wire Secure Memory Command Front End

This block is the serial slave side of a small secure memory. It watches a two-wire bus (a clock line and an open-drain data line) through synchronizers on a faster system clock. It detects start and stop conditions and shifts in bytes most significant bit first. It acknowledges bytes addressed to it. The first byte of every transaction carries a chip-select nibble and a command nibble. The block responds to a fixed select value and also to a second value supplied on a configuration input.

Memory reads and page writes go to a 256-byte register array. The array is split into four 64-byte zones, and the zone is chosen by two bits of the command. A read fuse command streams a status byte. Password and authentication commands are acknowledged and consumed with no effect. Two permit inputs stand in for access control. After every memory write, a parameterised busy interval models the nonvolatile write. During that interval a new command is not acknowledged, so the host can poll until the write is done.

Top module: `twowire_mem_front`

## Requirements
- R1: After reset the data line is released. Bits clocked without a preceding start condition (data falling while clock is high) are not acknowledged. A stop condition (data rising while clock is high) ends any transaction.
- R2: Received bytes are taken most significant bit first. An accepted byte is acknowledged by pulling data low for the whole ninth clock. The block changes its data drive only while the clock is low.
- R3: Command byte bits 7:4 are a chip select. The values 4'b1011 and `cs_prog` are accepted. Any other value is not acknowledged, and the rest of the transaction is ignored.
- R4: Command low nibble zz01 is a memory read in zone zz (bits 3:2). The next byte gives the in-zone address in bits 5:0. Data bytes then go out MSB first, and the address advances by one after each byte.
- R5: During a read, the address wraps from byte 63 of the current zone to byte 0 of the same zone.
- R6: Command low nibble zz00 is a memory write with the same address byte. After each data byte, only address bits 2:0 increment, so writes wrap within their 8-byte page.
- R7: While `rd_permit` is low, every read data byte is returned as 8'h00.
- R8: While `wr_permit` is low, write data bytes are acknowledged but leave the memory unchanged.
- R9: A stop that ends a memory write with at least one data byte starts a busy interval of WR_CYCLES clocks. During that interval a command byte is not acknowledged. Afterwards it is acknowledged again.
- R10: Command low nibble 4'b1110 returns {5'b0, fuse_state[2:0]} on every byte for as long as the host acknowledges.
- R11: A host not-acknowledge after a transmitted byte makes the block release the data line for the rest of that transaction.
- R12: Command low nibbles xx11, 0010, 0110 and 1010 are acknowledged with all following bytes. They do not change memory contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_drive_low | output | 1 | 1 pulls the open-drain data line low |
| cs_prog | input | 4 | Programmable second chip-select value |
| rd_permit | input | 1 | Read allowed; if low, reads return zeros |
| wr_permit | input | 1 | Write allowed; if low, writes are dropped |
| fuse_state | input | 3 | Fuse bits {PER, CMA, FAB} returned by read fuse |

## Verification
The hardest situation to reach is a command byte that arrives while the write interval is still running. The bench makes the interval long enough to cover one full command byte. It then begins acknowledge polling immediately after the write's stop. This forces a refused first poll and an accepted later poll. The read wrap at the zone boundary is reached by first writing the last byte of one zone and the first byte of a neighbouring zone. A two-byte read across the boundary then shows which byte the address returned to.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_ADDR, ST_WDATA, ST_RDATA, ST_FUSE, ST_SINK, ST_IGNORE
  } tw_state_e;

  typedef enum logic [1:0] {OP_WR, OP_RD, OP_FUSE, OP_SINK} tw_op_e;

  function automatic tw_op_e tw_decode(input logic [3:0] lo);
    if (lo[1:0] == 2'b00) return OP_WR;
    if (lo[1:0] == 2'b01) return OP_RD;
    if (lo == 4'b1110)    return OP_FUSE;
    return OP_SINK;
  endfunction
endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] pipe;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe <= '1;
      prev <= 1'b1;
    end else begin
      pipe <= {pipe[STAGES-2:0], din};
      prev <= pipe[STAGES-1];
    end
  end

  assign lvl  = pipe[STAGES-1];
  assign rise = pipe[STAGES-1] & ~prev;
  assign fall = ~pipe[STAGES-1] & prev;
endmodule

// File: rtl/tw_zone_store.sv
module tw_zone_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
    rdata <= ram[raddr];
  end
endmodule

// File: rtl/tw_busy_timer.sv
module tw_busy_timer #(
  parameter int WR_CYCLES = 1000,
  localparam int CW = $clog2(WR_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  output logic busy
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (go)         cnt <= CW'(WR_CYCLES);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  // R9
  busy_bound_chk: assert property (@(posedge clk) disable iff (rst)
    go |=> (busy && cnt == CW'(WR_CYCLES)));
endmodule

// File: rtl/twowire_mem_front.sv
module twowire_mem_front #(
  parameter int         NUM_ZONES  = 4,
  parameter int         ZONE_BYTES = 64,
  parameter int         PAGE_BYTES = 8,
  parameter int         WR_CYCLES  = 1000,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] FIXED_CS   = 4'b1011
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_drive_low,
  input  logic [3:0] cs_prog,
  input  logic       rd_permit,
  input  logic       wr_permit,
  input  logic [2:0] fuse_state
);
  import tw_pkg::*;

  localparam int AW  = $clog2(ZONE_BYTES);
  localparam int ZW  = $clog2(NUM_ZONES);
  localparam int PW  = $clog2(PAGE_BYTES);
  localparam int MAW = AW + ZW;

  logic scl_lvl, scl_rise, scl_fall, sda_lvl, sda_rise, sda_fall;

  tw_line_sync #(.STAGES(SYNC_STAGES)) u_scl (
    .clk(clk), .rst(rst), .din(scl_i), .lvl(scl_lvl), .rise(scl_rise), .fall(scl_fall));
  tw_line_sync #(.STAGES(SYNC_STAGES)) u_sda (
    .clk(clk), .rst(rst), .din(sda_i), .lvl(sda_lvl), .rise(sda_rise), .fall(sda_fall));

  logic start_ev, stop_ev;
  assign start_ev = scl_lvl & sda_fall;
  assign stop_ev  = scl_lvl & sda_rise;

  tw_state_e      st;
  logic [3:0]     bitcnt;
  logic [7:0]     shreg, tx;
  logic           tx_mode, is_rd, wrote, busy_go, busy;
  logic [ZW-1:0]  zone;
  logic [AW-1:0]  addr;
  logic           mem_we;
  logic [MAW-1:0] mem_wa;
  logic [7:0]     mem_wd, mem_q, nxt_byte;
  logic           cs_hit, active;

  tw_zone_store #(.DW(8), .DEPTH(NUM_ZONES * ZONE_BYTES)) u_store (
    .clk(clk), .we(mem_we), .waddr(mem_wa), .wdata(mem_wd),
    .raddr({zone, addr}), .rdata(mem_q));

  tw_busy_timer #(.WR_CYCLES(WR_CYCLES)) u_busy (
    .clk(clk), .rst(rst), .go(busy_go), .busy(busy));

  assign cs_hit   = (shreg[7:4] == FIXED_CS) || (shreg[7:4] == cs_prog);
  assign active   = (st != ST_IDLE) && (st != ST_IGNORE);
  assign nxt_byte = (st == ST_FUSE) ? {5'b0, fuse_state} : (rd_permit ? mem_q : 8'h00);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; bitcnt <= '0; shreg <= '0; tx <= '0; tx_mode <= 1'b0;
      is_rd <= 1'b0; wrote <= 1'b0; busy_go <= 1'b0; zone <= '0; addr <= '0;
      mem_we <= 1'b0; mem_wa <= '0; mem_wd <= '0; sda_drive_low <= 1'b0;
    end else begin
      busy_go <= 1'b0;
      mem_we  <= 1'b0;
      if (start_ev) begin
        st <= ST_CMD; bitcnt <= '0; tx_mode <= 1'b0; wrote <= 1'b0; sda_drive_low <= 1'b0;
      end else if (stop_ev) begin
        busy_go <= (st == ST_WDATA) && wrote;
        st <= ST_IDLE; sda_drive_low <= 1'b0;
      end else if (scl_rise && active) begin
        if (bitcnt < 4'd8) begin
          if (!tx_mode) shreg <= {shreg[6:0], sda_lvl};
          bitcnt <= bitcnt + 1'b1;
        end else begin
          bitcnt <= 4'd9;
          if (tx_mode && sda_lvl) st <= ST_IGNORE;  // host declined more data
        end
      end else if (scl_fall && active) begin
        if (bitcnt == 4'd8) begin
          if (tx_mode) begin
            sda_drive_low <= 1'b0;
            if (st == ST_RDATA) addr <= addr + 1'b1;
          end else begin
            unique case (st)
              ST_CMD: begin
                if (cs_hit && !busy) begin
                  sda_drive_low <= 1'b1;
                  zone <= shreg[ZW+1:2];
                  unique case (tw_decode(shreg[3:0]))
                    OP_WR:   begin st <= ST_ADDR; is_rd <= 1'b0; end
                    OP_RD:   begin st <= ST_ADDR; is_rd <= 1'b1; end
                    OP_FUSE: st <= ST_FUSE;
                    default: st <= ST_SINK;
                  endcase
                end else begin
                  st <= ST_IGNORE;
                end
              end
              ST_ADDR: begin
                addr <= shreg[AW-1:0];
                sda_drive_low <= 1'b1;
                st <= is_rd ? ST_RDATA : ST_WDATA;
              end
              ST_WDATA: begin
                mem_we <= wr_permit;
                mem_wa <= {zone, addr};
                mem_wd <= shreg;
                addr   <= {addr[AW-1:PW], addr[PW-1:0] + 1'b1};
                wrote  <= 1'b1;
                sda_drive_low <= 1'b1;
              end
              default: sda_drive_low <= 1'b1;
            endcase
          end
        end else if (bitcnt == 4'd9) begin
          bitcnt <= '0;
          if (st == ST_RDATA || st == ST_FUSE) begin
            tx_mode <= 1'b1;
            tx <= nxt_byte;
            sda_drive_low <= ~nxt_byte[7];
          end else begin
            tx_mode <= 1'b0;
            sda_drive_low <= 1'b0;
          end
        end else if (tx_mode && bitcnt != 4'd0) begin
          tx <= {tx[6:0], 1'b0};
          sda_drive_low <= ~tx[6];
        end
      end
    end
  end

  // R2
  sda_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (scl_lvl && $past(scl_lvl)) |-> $stable(sda_drive_low));

  // R9
  busy_nack_chk: assert property (@(posedge clk) disable iff (rst)
    (scl_fall && st == ST_CMD && !tx_mode && bitcnt == 4'd8 && busy) |=> !sda_drive_low);

  // R6
  page_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WDATA && $past(st) == ST_WDATA) |-> (addr[AW-1:PW] == $past(addr[AW-1:PW])));

  // R5
  rd_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (scl_fall && tx_mode && st == ST_RDATA && bitcnt == 4'd8 && addr == '1)
      |=> (addr == '0 && $stable(zone)));

  // R8
  mem_we_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(wr_permit));
endmodule

// File: tb/tb_twowire_mem_front.sv
module tb_twowire_mem_front;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst, scl, host_sda, drv, rd_permit, wr_permit;
  logic [3:0] cs_prog;
  logic [2:0] fuse_state;
  wire        sda_line = host_sda & ~drv;
  int         errs = 0, checks = 0;
  logic [7:0] rbuf [4];

  twowire_mem_front #(.WR_CYCLES(400)) dut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .sda_drive_low(drv),
    .cs_prog(cs_prog), .rd_permit(rd_permit), .wr_permit(wr_permit), .fuse_state(fuse_state));

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    host_sda = 1'b1; w(5); scl = 1'b1; w(10); host_sda = 1'b0; w(10); scl = 1'b0; w(5);
  endtask

  task automatic bus_stop();
    host_sda = 1'b0; w(5); scl = 1'b1; w(10); host_sda = 1'b1; w(10);
  endtask

  task automatic put_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      host_sda = b[i]; w(5); scl = 1'b1; w(10); scl = 1'b0; w(5);
    end
    host_sda = 1'b1; w(5); scl = 1'b1; w(5); acked = !sda_line; w(5); scl = 1'b0; w(5);
  endtask

  task automatic get_byte(output logic [7:0] b, input bit give_ack);
    host_sda = 1'b1;
    for (int i = 0; i < 8; i++) begin
      w(5); scl = 1'b1; w(5); b = {b[6:0], sda_line}; w(5); scl = 1'b0;
    end
    w(5); host_sda = give_ack ? 1'b0 : 1'b1; w(5); scl = 1'b1; w(10); scl = 1'b0;
    host_sda = 1'b1; w(5);
  endtask

  task automatic write_bytes(input logic [3:0] cs, input logic [1:0] z, input logic [5:0] a,
                             input logic [7:0] d0, d1, d2, input int n, output bit all_ack);
    bit ok;
    logic [7:0] d [3];
    d[0] = d0; d[1] = d1; d[2] = d2;
    bus_start();
    put_byte({cs, z, 2'b00}, ok); all_ack = ok;
    put_byte({2'b00, a}, ok);     all_ack &= ok;
    for (int k = 0; k < n; k++) begin
      put_byte(d[k], ok); all_ack &= ok;
    end
    bus_stop();
  endtask

  task automatic read_bytes(input logic [3:0] cs, input logic [1:0] z, input logic [5:0] a,
                            input int n);
    bit ok;
    bus_start();
    put_byte({cs, z, 2'b01}, ok);
    put_byte({2'b00, a}, ok);
    for (int k = 0; k < n; k++) get_byte(rbuf[k], k < n - 1);
    bus_stop();
  endtask

  task automatic wait_ready(output int polls);
    bit ok;
    polls = 0;
    do begin
      bus_start(); put_byte(8'hB1, ok); bus_stop(); polls++;
    end while (!ok && polls < 20);
  endtask

  task automatic t_reset();
    w(3);
    check("R1 data released after reset", int'(sda_line), 1);
  endtask

  task automatic t_write_read();
    bit ok; int polls;
    write_bytes(4'hB, 2'd1, 6'h10, 8'hA1, 8'hB2, 8'hC3, 3, ok);
    check("R2 write bytes acknowledged", int'(ok), 1);
    bus_start(); put_byte(8'hB1, ok); bus_stop();
    check("R9 command refused while busy", int'(ok), 0);
    wait_ready(polls);
    check("R9 command accepted after busy", int'(polls < 20), 1);
    read_bytes(4'h5, 2'd1, 6'h10, 3);
    check("R3 R4 readback byte0 via programmable select", rbuf[0], 8'hA1);
    check("R4 readback byte1", rbuf[1], 8'hB2);
    check("R4 readback byte2", rbuf[2], 8'hC3);
  endtask

  task automatic t_page_wrap();
    bit ok; int polls;
    write_bytes(4'hB, 2'd2, 6'h06, 8'h11, 8'h22, 8'h33, 3, ok);
    wait_ready(polls);
    read_bytes(4'hB, 2'd2, 6'h06, 2);
    check("R6 page byte 6", rbuf[0], 8'h11);
    check("R6 page byte 7", rbuf[1], 8'h22);
    read_bytes(4'hB, 2'd2, 6'h00, 1);
    check("R6 third byte wrapped to page start", rbuf[0], 8'h33);
  endtask

  task automatic t_read_wrap();
    bit ok; int polls;
    write_bytes(4'hB, 2'd2, 6'h3F, 8'h5A, 8'h00, 8'h00, 1, ok); wait_ready(polls);
    write_bytes(4'hB, 2'd3, 6'h00, 8'h6B, 8'h00, 8'h00, 1, ok); wait_ready(polls);
    read_bytes(4'hB, 2'd2, 6'h3F, 2);
    check("R5 last byte of zone", rbuf[0], 8'h5A);
    check("R5 wrap to start of same zone", rbuf[1], 8'h33);
  endtask

  task automatic t_permits();
    bit ok; int polls;
    rd_permit = 1'b0;
    read_bytes(4'hB, 2'd1, 6'h10, 1);
    check("R7 denied read returns zero", rbuf[0], 8'h00);
    rd_permit = 1'b1;
    wr_permit = 1'b0;
    write_bytes(4'hB, 2'd1, 6'h10, 8'hFF, 8'h00, 8'h00, 1, ok);
    wr_permit = 1'b1;
    wait_ready(polls);
    read_bytes(4'hB, 2'd1, 6'h10, 1);
    check("R8 denied write left data", rbuf[0], 8'hA1);
  endtask

  task automatic t_bad_select();
    bit ok;
    bus_start(); put_byte(8'h31, ok); bus_stop();
    check("R3 foreign select not acknowledged", int'(ok), 0);
  endtask

  task automatic t_fuse();
    bit ok; logic [7:0] b;
    fuse_state = 3'b101;
    bus_start(); put_byte(8'hBE, ok);
    get_byte(rbuf[0], 1'b1);
    get_byte(rbuf[1], 1'b0);
    check("R10 fuse byte first", rbuf[0], 8'h05);
    check("R10 fuse byte repeated", rbuf[1], 8'h05);
    get_byte(b, 1'b0);
    check("R11 line released after host nack", b, 8'hFF);
    bus_stop();
  endtask

  task automatic t_sink();
    bit ok, all;
    bus_start(); put_byte(8'hB3, ok); all = ok;
    put_byte(8'h12, ok); all &= ok;
    put_byte(8'h34, ok); all &= ok;
    put_byte(8'h56, ok); all &= ok;
    bus_stop();
    check("R12 password command acknowledged", int'(all), 1);
    bus_start(); put_byte(8'hB6, ok); put_byte(8'h10, ok); bus_stop();
    read_bytes(4'hB, 2'd1, 6'h10, 1);
    check("R12 memory unchanged by other commands", rbuf[0], 8'hA1);
  endtask

  task automatic t_no_start();
    bit ok;
    scl = 1'b0; w(5);
    put_byte(8'hB1, ok);
    bus_stop();
    check("R1 byte without start not acknowledged", int'(ok), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; scl = 1'b1; host_sda = 1'b1; cs_prog = 4'h5;
    rd_permit = 1'b1; wr_permit = 1'b1; fuse_state = 3'b000;
    w(5); rst = 1'b0;
    t_reset();
    t_write_read();
    t_page_wrap();
    t_read_wrap();
    t_permits();
    t_bad_select();
    t_fuse();
    t_sink();
    t_no_start();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule